// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block takes four interrupt request lines and resolves them with a fixed priority. Line 0 always wins over the others, and line 3 only wins when it is the sole active line. The winning line's index becomes a 2-bit code. A global enable flag decides whether any active request raises the interrupt line towards the processor.

The processor answers with an acknowledge signal. The block sees acknowledge go high, captures the winning code at that clock edge and clears the global enable. From the next cycle on it presents an 8-bit vector on its output with the output enable high. The vector is a fixed base value with the code placed in bits [3:2]. The output enable stays high for as long as acknowledge is held. The processor re-arms the block by pulsing the enable-set input, and it can disarm it with the enable-clear input.

Top module: `vec_irq_ctrl`

## Requirements
- R1: When request line 0 is active, the selected code is 00 whatever the other lines do, so vector bits [3:2] are 00.
- R2: With line 0 inactive, line 1 selects code 01. With lines 0 and 1 inactive, line 2 selects 10. With only line 3 active, the code is 11.
- R3: `intr_o` is high in exactly the cycles where the enable flag is set and at least one request line is active. It follows the request lines without a register delay.
- R4: The enable flag is clear after reset. A pulse on `ien_set_i` sets it at the next clock edge, and a pulse on `ien_clr_i` clears it there. When both are high together, clear wins.
- R5: The clock edge at which `intack_i` is first sampled high clears the enable flag, even if `ien_set_i` is high in that same cycle.
- R6: `vec_oe_o` goes high one clock edge after `intack_i` is sampled high and goes low one edge after it is sampled low. While `vec_oe_o` is low, `vec_o` is all zeros.
- R7: `vec_o` equals the base value (default 0x43) with bits [3:2] replaced by the code selected at the edge where acknowledge was first sampled high. Default vectors are 0x43, 0x47, 0x4B and 0x4F for codes 00 to 11. Request changes while acknowledge is held do not alter the vector.
- R8: An acknowledge with no request active captures code 00, giving the base vector 0x43.
- R9: After reset, `intr_o`, `vec_oe_o` and `vec_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 4 | Request lines; bit 0 has the highest priority |
| ien_set_i | input | 1 | Sets the global enable flag |
| ien_clr_i | input | 1 | Clears the global enable flag |
| intack_i | input | 1 | Interrupt acknowledge from the processor |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Interrupt vector, zero when not enabled |
| vec_oe_o | output | 1 | Vector output enable |

## Verification
The assertions assume that `intack_i` is held low throughout reset and is a clean, synchronous level. Because of this, its first high sample after reset counts as a true rising edge.

The assertions also assume that the request lines are known values at every clock edge. They do not assume that requests stay steady during acknowledge.

The bench drives all inputs only at falling clock edges, keeps acknowledge low while reset is asserted, and deliberately changes the requests while acknowledge is held. This exercises the capture behaviour without breaking those assumptions.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VIC_NUM_SRC = 4;
    localparam int VIC_CODE_W  = $clog2(VIC_NUM_SRC);
    localparam int VIC_VEC_W   = 8;

    typedef struct packed {
        logic                  ien;
        logic                  oe;
        logic [VIC_CODE_W-1:0] code;
    } vic_state_t;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int NUM_SRC = 4,
    localparam int CODE_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               any_o
);
    // seen_above[i]: some line with higher priority than i is active
    logic [NUM_SRC:0]   seen_above;
    logic [NUM_SRC-1:0] grant;

    assign seen_above[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign grant[g]        = req_i[g] & ~seen_above[g];
        assign seen_above[g+1] = seen_above[g] | req_i[g];
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                code_o = code_o | CODE_W'(i);
            end
        end
    end

    assign any_o = seen_above[NUM_SRC];
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ien_set_i,
    input  logic                  ien_clr_i,
    input  logic                  intack_i,
    input  logic [VIC_CODE_W-1:0] code_i,
    output logic                  ien_o,
    output logic                  oe_o,
    output logic [VIC_CODE_W-1:0] code_o
);
    vic_state_t st_d, st_q;
    logic       ack_rise;

    // oe_q doubles as the previous sample of the acknowledge line
    assign ack_rise = intack_i & ~st_q.oe;

    always_comb begin
        st_d    = st_q;
        st_d.oe = intack_i;
        if (ack_rise) begin
            st_d.code = code_i;
            st_d.ien  = 1'b0;
        end else if (ien_clr_i) begin
            st_d.ien  = 1'b0;
        end else if (ien_set_i) begin
            st_d.ien  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ien_o  = st_q.ien;
    assign oe_o   = st_q.oe;
    assign code_o = st_q.code;

    p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(intack_i) |=> !ien_o);
    p_clr_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ien_clr_i |=> !ien_o);
    p_oe_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        intack_i |=> oe_o);
    p_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !intack_i |=> !oe_o);
    p_code_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (intack_i && oe_o) |=> $stable(code_o));
endmodule

// File: rtl/vic_vec_fmt.sv
module vic_vec_fmt #(
    parameter int          VEC_W    = 8,
    parameter int          CODE_W   = 2,
    parameter int          CODE_LSB = 2,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h43
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              oe_i,
    output logic [VEC_W-1:0]  vec_o
);
    localparam logic [VEC_W-1:0] CODE_MASK =
        VEC_W'(((1 << CODE_W) - 1) << CODE_LSB);
    localparam logic [VEC_W-1:0] BASE_KEEP = VEC_BASE & ~CODE_MASK;

    logic [VEC_W-1:0] placed;

    assign placed = VEC_W'(code_i) << CODE_LSB;
    assign vec_o  = oe_i ? (BASE_KEEP | placed) : '0;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int                    CODE_LSB = 2,
    parameter logic [VIC_VEC_W-1:0]  VEC_BASE = 8'h43
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [VIC_NUM_SRC-1:0] irq_req_i,
    input  logic                   ien_set_i,
    input  logic                   ien_clr_i,
    input  logic                   intack_i,
    output logic                   intr_o,
    output logic [VIC_VEC_W-1:0]   vec_o,
    output logic                   vec_oe_o
);
    logic [VIC_CODE_W-1:0]  enc_code;
    logic                   enc_any;
    logic                   ien;
    logic                   oe;
    logic [VIC_CODE_W-1:0]  held_code;
    logic [VIC_NUM_SRC-1:0] lower_mask;

    vic_prio_enc #(.NUM_SRC(VIC_NUM_SRC)) i_enc (
        .req_i  (irq_req_i),
        .code_o (enc_code),
        .any_o  (enc_any)
    );

    vic_ctrl i_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ien_set_i (ien_set_i),
        .ien_clr_i (ien_clr_i),
        .intack_i  (intack_i),
        .code_i    (enc_code),
        .ien_o     (ien),
        .oe_o      (oe),
        .code_o    (held_code)
    );

    vic_vec_fmt #(
        .VEC_W    (VIC_VEC_W),
        .CODE_W   (VIC_CODE_W),
        .CODE_LSB (CODE_LSB),
        .VEC_BASE (VEC_BASE)
    ) i_fmt (
        .code_i (held_code),
        .oe_i   (oe),
        .vec_o  (vec_o)
    );

    assign intr_o   = enc_any & ien;
    assign vec_oe_o = oe;

    // lines with higher priority than the selected one
    assign lower_mask = (VIC_NUM_SRC'(1) << enc_code) - VIC_NUM_SRC'(1);

    p_line0_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_i[0] |-> (enc_code == '0));
    p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enc_any |-> (irq_req_i[enc_code] && ((irq_req_i & lower_mask) == '0)));
    p_intr_needs_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        intr_o |-> (irq_req_i != '0));
    p_idle_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_oe_o |-> (vec_o == '0));
    p_vec_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_oe_o && intack_i) |=> $stable(vec_o));
endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       set = 1'b0;
    logic       clr = 1'b0;
    logic       ack = 1'b0;
    logic       intr;
    logic [7:0] vec;
    logic       oe;
    int         total = 0;
    int         bad = 0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .ien_set_i(set),
        .ien_clr_i(clr), .intack_i(ack), .intr_o(intr), .vec_o(vec),
        .vec_oe_o(oe)
    );

    // {request, request during acknowledge, expected vector}
    localparam logic [15:0] TBL [9] = '{
        {4'b1111, 4'b0000, 8'h43},   // R1
        {4'b0001, 4'b1110, 8'h43},   // R1
        {4'b1110, 4'b0001, 8'h47},   // R2
        {4'b0010, 4'b0000, 8'h47},   // R2
        {4'b1100, 4'b1111, 8'h4B},   // R2
        {4'b0100, 4'b0011, 8'h4B},   // R2
        {4'b1000, 4'b0111, 8'h4F},   // R2
        {4'b1010, 4'b0100, 8'h47},   // R2
        {4'b0000, 4'b1000, 8'h43}    // R8
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #500000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        check("R9 intr", 8'(intr), 8'h0);
        check("R9 oe", 8'(oe), 8'h0);
        check("R9 vec", vec, 8'h00);
        rst_n = 1'b1;
        step();

        // R3/R4: no enable yet, request gives no interrupt
        req = 4'b0100;
        step();
        check("R3 disabled", 8'(intr), 8'h0);

        // R4: set takes effect at the next edge
        set = 1'b1;
        #1 check("R4 before edge", 8'(intr), 8'h0);
        step();
        set = 1'b0;
        check("R4 set", 8'(intr), 8'h1);
        req = 4'b0000;
        #1 check("R3 no request", 8'(intr), 8'h0);
        req = 4'b1000;
        #1 check("R3 comb follow", 8'(intr), 8'h1);

        // R4: clear beats set
        set = 1'b1; clr = 1'b1;
        step();
        set = 1'b0; clr = 1'b0;
        check("R4 clr wins", 8'(intr), 8'h0);

        // Table walk: R1, R2, R5, R6, R7, R8
        for (int k = 0; k < 9; k++) begin
            req = TBL[k][15:12];
            set = 1'b1;
            step();
            set = 1'b0;
            check("R3 armed", 8'(intr), 8'(req != 4'b0000));
            ack = 1'b1;
            #1 check("R6 oe before edge", 8'(oe), 8'h0);
            step();
            check("R6 oe on", 8'(oe), 8'h1);
            check("R7 vector", vec, TBL[k][7:0]);
            check("R5 ien cleared", 8'(intr), 8'h0);
            req = TBL[k][11:8];
            step();
            check("R7 held vector", vec, TBL[k][7:0]);
            ack = 1'b0;
            step();
            check("R6 oe off", 8'(oe), 8'h0);
            check("R6 idle bus", vec, 8'h00);
        end

        // R5: acknowledge rising with set in the same cycle clears enable
        req = 4'b0010;
        set = 1'b1;
        step();
        ack = 1'b1;
        step();
        set = 1'b0;
        check("R5 ack beats set", 8'(intr), 8'h0);
        check("R2 line1 vector", vec, 8'h47);
        ack = 1'b0;
        step();

        // R9: reset mid-operation returns outputs to zero
        set = 1'b1;
        step();
        set = 1'b0;
        ack = 1'b1;
        step();
        rst_n = 1'b0;
        ack = 1'b0;
        #1;
        check("R9 reset intr", 8'(intr), 8'h0);
        check("R9 reset vec", vec, 8'h00);
        check("R9 reset oe", 8'(oe), 8'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule